// File: doc/BRIEF.md
# Packed-Flag Arithmetic and Logic Unit

This block is the combinational datapath core of a small accumulator processor. A 5-bit operation code selects one of sixteen operations on two operand buses and the current flag byte. The block returns a result word and a new flag byte within the same cycle. The eight-bit operations cover addition and subtraction with or without incoming carry, compare, increment and decrement, and the bitwise AND, XOR and OR. It also provides decimal adjust after BCD arithmetic, complement of the accumulator, and set or invert of the carry flag. Two sixteen-bit operations complete the set: a register-pair add, and a stack-pointer add of a signed byte offset.

The flag byte is packed into its upper nibble: zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Its lower nibble always reads as zero. Eight-bit operations take the low byte of `opa` as the accumulator and the low byte of `opb` as the second operand. They return their value in the low byte of `res_o`, with the high byte zero. The register file, instruction decode and sequencing sit outside this block. The surrounding pipeline latches `res_o` and `flags_o` wherever it needs them.

Top module: `packed_flag_alu`

## Requirements
- R1: `flags_o[3:0]` is always 0. The flags sit at Z=bit7, N=bit6, H=bit5 and C=bit4 in both `flags_i` and `flags_o`.
- R2: ADD (code 0) and ADC (code 1) return a+b (+C for ADC) in the low byte. Z is set for a zero byte, N=0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R3: SUB (code 2) and SBC (code 3) return a-b (-C for SBC). Z is set for a zero byte, N=1, H is the borrow from bit 4 and C is the borrow from bit 8.
- R4: CP (code 7) produces the SUB flags but returns the unchanged accumulator byte.
- R5: AND (code 4) gives H=1, N=0, C=0. XOR (code 5) and OR (code 6) give H=N=C=0. All three set Z from the result byte.
- R6: INC (code 8) and DEC (code 9) act on the accumulator byte and keep C. INC gives N=0 and sets H when the result's low nibble is 0. DEC gives N=1 and sets H when the operand's low nibble is 0. Both set Z from the result.
- R7: DAA (code 10) with N=0 adds 6 if H is set or the low nibble exceeds 9. It then adds 0x60 if C is set or the value exceeds 0x9F. New C is the old C ORed with the overflow into bit 8.
- R8: DAA with N=1 subtracts 6 if H is set, then 0x60 if C is set. In both DAA modes H is cleared, N and C are kept, and Z follows the result.
- R9: CPL (code 11) inverts the accumulator and sets H and N. SCF (code 12) sets C and CCF (code 13) inverts C, both clearing H and N and returning the accumulator. All three keep Z.
- R10: Pair add (code 14) returns the 16-bit sum of `opa` and `opb`. N=0, H is the carry out of bit 11, C is the carry out of bit 15, and Z is kept.
- R11: Stack offset add (code 15) returns `opa` plus the sign-extended `opb[7:0]`. Z=N=0. H and C are the carries out of bits 3 and 7 of the low byte.
- R12: Codes 16 to 31 return `opa` unchanged, with the flag nibble of `flags_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| opa | input | 16 | Accumulator byte (low) or 16-bit first operand / stack pointer |
| opb | input | 16 | Second operand byte (low), 16-bit addend, or signed offset (low byte) |
| flags_i | input | 8 | Current packed flag byte |
| res_o | output | 16 | Result word |
| flags_o | output | 8 | New packed flag byte |

## Verification
The checker's immediate assertions assume that all inputs are known values. They also assume the checker evaluates only after the combinational paths have settled for the current input set. The bench therefore changes the code, both operands and the flag byte together at one instant. It then waits a quarter period before sampling, so no check sees a mix of old and new inputs. Stimulus uses every defined code and two codes from the unused range. The flag inputs carry nonzero low-nibble bits in some vectors, to show that they never reach the output.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;

    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_XOR  = 5'd5,
        OP_OR   = 5'd6,
        OP_CP   = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_DAA  = 5'd10,
        OP_CPL  = 5'd11,
        OP_SCF  = 5'd12,
        OP_CCF  = 5'd13,
        OP_ADDW = 5'd14,
        OP_SPOF = 5'd15
    } alu_op_e;

    function automatic logic is_zero8(input logic [BYTE_W-1:0] v);
        return (v == '0);
    endfunction
endpackage

// File: rtl/pfa_addsub.sv
module pfa_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              hc,
    output logic              cy
);
    localparam int NIB = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [NIB:0]    low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
        sum = full[DATA_W-1:0];
        cy  = full[DATA_W];
        hc  = low[NIB];
    end
endmodule

// File: rtl/pfa_decadj.sv
module pfa_decadj (
    input  logic [7:0] a,
    input  logic       nf,
    input  logic       hf,
    input  logic       cf,
    output logic [7:0] adj,
    output logic       cy
);
    localparam logic [9:0] LO_FIX = 10'h006;
    localparam logic [9:0] HI_FIX = 10'h060;
    localparam logic [9:0] HI_LIM = 10'h09F;
    localparam logic [3:0] NIB_LIM = 4'd9;

    logic [9:0] v;

    always_comb begin
        v = {2'b00, a};
        if (nf) begin
            if (hf) v = (v - LO_FIX) & 10'h0FF;
            if (cf) v = v - HI_FIX;
            cy = cf;
        end else begin
            if (hf || (a[3:0] > NIB_LIM)) v = v + LO_FIX;
            if (cf || (v > HI_LIM))       v = v + HI_FIX;
            cy = cf | v[8];
        end
        adj = v[7:0];
    end

    logic unused_top;
    assign unused_top = v[9];
endmodule

// File: rtl/pfa_wide.sv
module pfa_wide #(
    parameter int DATA_W = 8
) (
    input  logic [2*DATA_W-1:0] a,
    input  logic [2*DATA_W-1:0] b,
    input  logic                offs_mode,
    output logic [2*DATA_W-1:0] sum,
    output logic                hc,
    output logic                cy
);
    localparam int WIDE = 2 * DATA_W;
    localparam int NIB  = DATA_W / 2;
    localparam int HBIT = WIDE - NIB;

    logic [WIDE-1:0] addend;
    logic [WIDE:0]   full;
    logic [HBIT:0]   upper_low;

    always_comb begin
        if (offs_mode) addend = {{DATA_W{b[DATA_W-1]}}, b[DATA_W-1:0]};
        else           addend = b;
        full      = {1'b0, a} + {1'b0, addend};
        upper_low = {1'b0, a[HBIT-1:0]} + {1'b0, addend[HBIT-1:0]};
        sum       = full[WIDE-1:0];
        if (offs_mode) begin
            hc = a[NIB] ^ addend[NIB] ^ full[NIB];
            cy = a[DATA_W] ^ addend[DATA_W] ^ full[DATA_W];
        end else begin
            hc = upper_low[HBIT];
            cy = full[WIDE];
        end
    end
endmodule

// File: rtl/packed_flag_alu.sv
module packed_flag_alu
    import pfa_pkg::*;
(
    input  logic [4:0]        op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [7:0]        flags_i,
    output logic [WORD_W-1:0] res_o,
    output logic [7:0]        flags_o
);
    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    logic [BYTE_W-1:0] acc, src;
    assign acc = opa[BYTE_W-1:0];
    assign src = opb[BYTE_W-1:0];

    logic cin_z, cin_n, cin_h, cin_c;
    assign cin_z = flags_i[FZ];
    assign cin_n = flags_i[FN];
    assign cin_h = flags_i[FH];
    assign cin_c = flags_i[FC];

    // Main adder/subtractor: ADD, ADC, SUB, SBC, CP
    logic main_sub, main_cin;
    logic [BYTE_W-1:0] main_sum;
    logic main_h, main_c;
    assign main_sub = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CP);
    assign main_cin = ((op_e == OP_ADC) || (op_e == OP_SBC)) ? cin_c : 1'b0;

    pfa_addsub #(.DATA_W(BYTE_W)) u_main (
        .a(acc), .b(src), .cin(main_cin), .sub(main_sub),
        .sum(main_sum), .hc(main_h), .cy(main_c)
    );

    // Step unit: INC, DEC
    logic [BYTE_W-1:0] step_sum;
    logic step_h, step_c;
    pfa_addsub #(.DATA_W(BYTE_W)) u_step (
        .a(acc), .b({{(BYTE_W-1){1'b0}}, 1'b1}), .cin(1'b0),
        .sub(op_e == OP_DEC),
        .sum(step_sum), .hc(step_h), .cy(step_c)
    );

    // Decimal adjust
    logic [BYTE_W-1:0] da_val;
    logic da_c;
    pfa_decadj u_da (
        .a(acc), .nf(cin_n), .hf(cin_h), .cf(cin_c),
        .adj(da_val), .cy(da_c)
    );

    // 16-bit pair add and stack offset add
    logic [WORD_W-1:0] w_sum;
    logic w_h, w_c;
    pfa_wide #(.DATA_W(BYTE_W)) u_wide (
        .a(opa), .b(opb), .offs_mode(op_e == OP_SPOF),
        .sum(w_sum), .hc(w_h), .cy(w_c)
    );

    logic [BYTE_W-1:0] r8;
    logic nz, nn, nh, nc;
    logic wide_sel;

    always_comb begin
        r8       = acc;
        wide_sel = 1'b0;
        nz = cin_z; nn = cin_n; nh = cin_h; nc = cin_c;
        unique case (op_e)
            OP_ADD, OP_ADC: begin
                r8 = main_sum;
                nz = is_zero8(main_sum); nn = 1'b0; nh = main_h; nc = main_c;
            end
            OP_SUB, OP_SBC: begin
                r8 = main_sum;
                nz = is_zero8(main_sum); nn = 1'b1; nh = main_h; nc = main_c;
            end
            OP_CP: begin
                r8 = acc;
                nz = is_zero8(main_sum); nn = 1'b1; nh = main_h; nc = main_c;
            end
            OP_AND: begin
                r8 = acc & src;
                nz = is_zero8(acc & src); nn = 1'b0; nh = 1'b1; nc = 1'b0;
            end
            OP_XOR: begin
                r8 = acc ^ src;
                nz = is_zero8(acc ^ src); nn = 1'b0; nh = 1'b0; nc = 1'b0;
            end
            OP_OR: begin
                r8 = acc | src;
                nz = is_zero8(acc | src); nn = 1'b0; nh = 1'b0; nc = 1'b0;
            end
            OP_INC: begin
                r8 = step_sum;
                nz = is_zero8(step_sum); nn = 1'b0; nh = step_h;
            end
            OP_DEC: begin
                r8 = step_sum;
                nz = is_zero8(step_sum); nn = 1'b1; nh = step_h;
            end
            OP_DAA: begin
                r8 = da_val;
                nz = is_zero8(da_val); nh = 1'b0; nc = da_c;
            end
            OP_CPL: begin
                r8 = ~acc;
                nn = 1'b1; nh = 1'b1;
            end
            OP_SCF: begin
                nn = 1'b0; nh = 1'b0; nc = 1'b1;
            end
            OP_CCF: begin
                nn = 1'b0; nh = 1'b0; nc = ~cin_c;
            end
            OP_ADDW: begin
                wide_sel = 1'b1;
                nn = 1'b0; nh = w_h; nc = w_c;
            end
            OP_SPOF: begin
                wide_sel = 1'b1;
                nz = 1'b0; nn = 1'b0; nh = w_h; nc = w_c;
            end
            default: begin
                wide_sel = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (wide_sel) begin
            res_o = (op_e == OP_ADDW || op_e == OP_SPOF) ? w_sum : opa;
        end else begin
            res_o = {{BYTE_W{1'b0}}, r8};
        end
        flags_o = {nz, nn, nh, nc, 4'b0000};
    end

    logic unused_in;
    assign unused_in = ^{flags_i[3:0], step_c};
endmodule

// File: rtl/packed_flag_alu_chk.sv
module packed_flag_alu_chk
    import pfa_pkg::*;
(
    input logic [4:0]        op,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic [7:0]        flags_i,
    input logic [WORD_W-1:0] res_o,
    input logic [7:0]        flags_o
);
    logic known;
    assign known = !$isunknown({op, opa, opb, flags_i});

    always_comb begin
        if (known) begin
            assert_low_nibble_zero_R1: assert (flags_o[3:0] == 4'b0000)
                else $error("R1 flag low nibble not zero");
            if (op == OP_CP) begin
                assert_cp_keeps_acc_R4: assert (res_o == {8'h00, opa[7:0]})
                    else $error("R4 compare altered accumulator");
            end
            if (op == OP_AND) begin
                assert_and_flags_R5: assert (flags_o[FH] && !flags_o[FN] && !flags_o[FC])
                    else $error("R5 AND flag pattern wrong");
            end
            if (op == OP_INC || op == OP_DEC) begin
                assert_step_keeps_carry_R6: assert (flags_o[FC] == flags_i[FC])
                    else $error("R6 step changed carry");
            end
            if (op == OP_ADDW) begin
                assert_pair_keeps_zero_R10: assert (flags_o[FZ] == flags_i[FZ] && !flags_o[FN])
                    else $error("R10 pair add Z/N wrong");
            end
            if (op == OP_SPOF) begin
                assert_offset_clears_zn_R11: assert (!flags_o[FZ] && !flags_o[FN])
                    else $error("R11 offset add Z/N not cleared");
            end
            if (op[4]) begin
                assert_unused_passthru_R12: assert (res_o == opa && flags_o[7:4] == flags_i[7:4])
                    else $error("R12 unused code not transparent");
            end
        end
    end

    logic unused_chk;
    assign unused_chk = ^opb;
endmodule

bind packed_flag_alu packed_flag_alu_chk u_chk (
    .op(op), .opa(opa), .opb(opb), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o)
);

// File: tb/packed_flag_alu_test.sv
module packed_flag_alu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op;
    logic [15:0] opa, opb;
    logic [7:0]  flags_i;
    logic [15:0] res_o;
    logic [7:0]  flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_flag_alu uut (
        .op(op), .opa(opa), .opb(opb), .flags_i(flags_i),
        .res_o(res_o), .flags_o(flags_o)
    );

    task automatic run_vec(input string req, input logic [4:0] o,
                           input logic [15:0] a, input logic [15:0] b,
                           input logic [7:0] f,
                           input logic [15:0] er, input logic [7:0] ef);
        @(negedge clk);
        op = o; opa = a; opb = b; flags_i = f;
        #(CLK_PERIOD/4);
        checks++;
        if (res_o !== er || flags_o !== ef) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h f=%h: res=%h flags=%h expected res=%h flags=%h",
                     req, o, a, b, f, res_o, flags_o, er, ef);
        end
    endtask

    task automatic test_reset;
        // R1: zero inputs after reset, ADD of zeros sets Z only
        run_vec("R1", 5'd0, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h80);
        run_vec("R1", 5'd0, 16'h0012, 16'h0034, 8'h0F, 16'h0046, 8'h00);
    endtask

    task automatic test_add;
        run_vec("R2", 5'd0, 16'h003A, 16'h00C6, 8'h00, 16'h0000, 8'hB0);
        run_vec("R2", 5'd0, 16'h000F, 16'h0001, 8'h10, 16'h0010, 8'h20);
        run_vec("R2", 5'd1, 16'h00FF, 16'h0000, 8'h10, 16'h0000, 8'hB0);
        run_vec("R2", 5'd1, 16'h000E, 16'h0001, 8'h10, 16'h0010, 8'h20);
    endtask

    task automatic test_sub;
        run_vec("R3", 5'd2, 16'h003E, 16'h000F, 8'h00, 16'h002F, 8'h60);
        run_vec("R3", 5'd2, 16'h0010, 16'h0020, 8'h00, 16'h00F0, 8'h50);
        run_vec("R3", 5'd2, 16'h0042, 16'h0042, 8'h00, 16'h0000, 8'hC0);
        run_vec("R3", 5'd3, 16'h003B, 16'h002A, 8'h10, 16'h0010, 8'h40);
        run_vec("R3", 5'd3, 16'h0000, 16'h0000, 8'h10, 16'h00FF, 8'h70);
    endtask

    task automatic test_cp;
        run_vec("R4", 5'd7, 16'h003C, 16'h0040, 8'h00, 16'h003C, 8'h50);
        run_vec("R4", 5'd7, 16'h0055, 16'h0055, 8'h00, 16'h0055, 8'hC0);
    endtask

    task automatic test_logic;
        run_vec("R5", 5'd4, 16'h00F0, 16'h000F, 8'h00, 16'h0000, 8'hA0);
        run_vec("R5", 5'd4, 16'h005A, 16'h003F, 8'h10, 16'h001A, 8'h20);
        run_vec("R5", 5'd5, 16'h00FF, 16'h00FF, 8'h00, 16'h0000, 8'h80);
        run_vec("R5", 5'd5, 16'h000F, 16'h00F0, 8'hF0, 16'h00FF, 8'h00);
        run_vec("R5", 5'd6, 16'h0000, 16'h0000, 8'h70, 16'h0000, 8'h80);
        run_vec("R5", 5'd6, 16'h0010, 16'h0001, 8'h00, 16'h0011, 8'h00);
    endtask

    task automatic test_step;
        run_vec("R6", 5'd8, 16'h00FF, 16'h0000, 8'h10, 16'h0000, 8'hB0);
        run_vec("R6", 5'd8, 16'h000E, 16'h0000, 8'h00, 16'h000F, 8'h00);
        run_vec("R6", 5'd9, 16'h0010, 16'h0000, 8'h10, 16'h000F, 8'h70);
        run_vec("R6", 5'd9, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'hC0);
    endtask

    task automatic test_daa_add;
        run_vec("R7", 5'd10, 16'h000F, 16'h0000, 8'h00, 16'h0015, 8'h00);
        run_vec("R7", 5'd10, 16'h009A, 16'h0000, 8'h00, 16'h0000, 8'h90);
        run_vec("R7", 5'd10, 16'h0022, 16'h0000, 8'h20, 16'h0028, 8'h00);
        run_vec("R7", 5'd10, 16'h0045, 16'h0000, 8'h10, 16'h00A5, 8'h10);
    endtask

    task automatic test_daa_sub;
        run_vec("R8", 5'd10, 16'h000F, 16'h0000, 8'h60, 16'h0009, 8'h40);
        run_vec("R8", 5'd10, 16'h00C0, 16'h0000, 8'h50, 16'h0060, 8'h50);
        run_vec("R8", 5'd10, 16'h0066, 16'h0000, 8'h70, 16'h0000, 8'hD0);
    endtask

    task automatic test_flagops;
        run_vec("R9", 5'd11, 16'h0035, 16'h0000, 8'h90, 16'h00CA, 8'hF0);
        run_vec("R9", 5'd12, 16'h0077, 16'h0000, 8'h60, 16'h0077, 8'h10);
        run_vec("R9", 5'd12, 16'h0077, 16'h0000, 8'h80, 16'h0077, 8'h90);
        run_vec("R9", 5'd13, 16'h0001, 16'h0000, 8'h70, 16'h0001, 8'h00);
        run_vec("R9", 5'd13, 16'h0001, 16'h0000, 8'h80, 16'h0001, 8'h90);
    endtask

    task automatic test_pair;
        run_vec("R10", 5'd14, 16'h0FFF, 16'h0001, 8'h80, 16'h1000, 8'hA0);
        run_vec("R10", 5'd14, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h30);
        run_vec("R10", 5'd14, 16'h1234, 16'h1111, 8'h40, 16'h2345, 8'h00);
    endtask

    task automatic test_offset;
        run_vec("R11", 5'd15, 16'hFFF8, 16'h0008, 8'hF0, 16'h0000, 8'h30);
        run_vec("R11", 5'd15, 16'h1000, 16'h00FF, 8'h00, 16'h0FFF, 8'h00);
        run_vec("R11", 5'd15, 16'h000F, 16'h0001, 8'h00, 16'h0010, 8'h20);
    endtask

    task automatic test_unused;
        run_vec("R12", 5'd16, 16'hBEEF, 16'h1234, 8'hF5, 16'hBEEF, 8'hF0);
        run_vec("R12", 5'd31, 16'h1234, 16'hFFFF, 8'h30, 16'h1234, 8'h30);
    endtask

    initial begin
        op = '0; opa = '0; opb = '0; flags_i = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_reset();
        test_add();
        test_sub();
        test_cp();
        test_logic();
        test_step();
        test_daa_add();
        test_daa_sub();
        test_flagops();
        test_pair();
        test_offset();
        test_unused();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule